// File: doc/BRIEF.md
# Scan Clock and Channel Sequencer

This block paces conversions for a four-channel acquisition front end that samples all channels at once. A 16-bit configuration word, loaded through a single write strobe, chooses which of four master clock enable inputs drives the timebase. It also sets a power-of-two divisor on that clock and a coded scan pattern. Every divided tick of the chosen clock produces a one-cycle sample strobe. Beside the strobe, the block presents the channel number that conversion belongs to, stepping upward through the selected channel group.

The same word carries a set of static controls, which the block drives straight out as level signals: the enable for each channel pair, AC coupling for each pair, and separate power-down flags for the analog and digital sections. While digital power-down is set, the sequencer is frozen at its starting point. The reset and resynchronise sequence (both power-down bits set, then analog power-down cleared) therefore always restarts the timebase from a clean phase.

Top module: `scan_seq_top`

## Requirements
- R1: After reset every output is 0, and the configuration word is 0 (scan code 0, clock 0, divisor shift 0, all flags clear).
- R2: Scan code 1 (bits 2:0) emits channels 0, 1, 2, 3 in ascending order, one per strobe, then wraps back to 0.
- R3: Scan code 2 alternates channels 0 and 1, and scan code 3 alternates channels 2 and 3, each starting from the lower channel.
- R4: Scan codes 4 to 7 emit only channel (code - 4) on every strobe.
- R5: Scan code 0 is idle, and no sample strobe is issued while it is selected.
- R6: Bits 4:3 pick which bit of `mclkEn` is counted. Enable pulses on the other three inputs have no effect on strobes.
- R7: With divisor shift s in bits 6:5, a strobe is issued on every 2^s-th counted enable pulse. The strobe is high in the cycle after the clock edge that sampled the completing pulse.
- R8: A write that changes any of bits 6:0 clears the divisor count and returns the scan to its first channel, and no strobe follows that write. A write that leaves bits 6:0 unchanged disturbs neither.
- R9: One cycle after a write, `pairEnable[0]` and `pairEnable[1]` follow bits 7 and 8, `acCouple[0]` and `acCouple[1]` follow bits 9 and 10, and `analogPd` and `digitalPd` follow bits 11 and 12.
- R10: While bit 12 (digital power-down) is set, no strobe is issued, `sampleChan` is 0, and the count and scan position are held at their start. After bit 12 clears, the first strobe comes a full divided period later, on the group's first channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Loads `cfgWrData` into the configuration word |
| cfgWrData | input | 16 | New configuration word |
| mclkEn | input | 4 | One enable pulse per master clock period, one bit per clock source |
| sampleStrobe | output | 1 | One-cycle conversion strobe |
| sampleChan | output | 2 | Channel of the latest strobe; 0 in digital power-down |
| pairEnable | output | 2 | Pair enables: bit 0 for channels 0/1, bit 1 for channels 2/3 |
| acCouple | output | 2 | AC coupling: bit 0 for pair 0/1, bit 1 for pair 2/3 |
| analogPd | output | 1 | Analog section power-down |
| digitalPd | output | 1 | Digital section power-down |

## Verification
Directed sequences cover each scan code in turn, so the channel order of the full scan, both pairs and the four singles are told apart. A dense enable on one unselected input shows that clock selection really gates the counter, and maximum divide under an every-cycle enable pins down the strobe spacing and latency. Rewriting an identical word, as against a changed one, separates a harmless reload from a restart. A power-down window shows the frozen state and the clean restart after release. Long runs of random enable patterns and occasional random words compare each cycle's strobe and channel against a bench model written from the requirements.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int CFG_W  = 16;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;
  localparam int DIV_W  = 2;
  localparam int CHAN_W = 2;

  // Field positions in the configuration word
  localparam int MODE_LSB  = 0;
  localparam int SEL_LSB   = MODE_LSB + MODE_W;
  localparam int DIV_LSB   = SEL_LSB + SEL_W;
  localparam int TIME_MSB  = DIV_LSB + DIV_W - 1;
  localparam int PAIR_LSB  = TIME_MSB + 1;
  localparam int AC_LSB    = PAIR_LSB + 2;
  localparam int APD_BIT   = AC_LSB + 2;
  localparam int DPD_BIT   = APD_BIT + 1;

  typedef struct packed {
    logic              restart;
    logic              hold;
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  clkSel;
    logic [DIV_W-1:0]  divShift;
  } seqCtl_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output seqCtl_t          ctl,
  output logic [1:0]       pairEnable,
  output logic [1:0]       acCouple,
  output logic             analogPd,
  output logic             digitalPd
);
  logic [CFG_W-1:0] cfgReg;
  logic             timeFieldsDiffer;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData;
  end

  assign timeFieldsDiffer = cfgWrData[TIME_MSB:0] != cfgReg[TIME_MSB:0];

  always_comb begin
    ctl.restart  = cfgWrEn && timeFieldsDiffer;
    ctl.hold     = cfgReg[DPD_BIT];
    ctl.mode     = cfgReg[MODE_LSB +: MODE_W];
    ctl.clkSel   = cfgReg[SEL_LSB +: SEL_W];
    ctl.divShift = cfgReg[DIV_LSB +: DIV_W];
  end

  for (genvar g = 0; g < 2; g++) begin : g_pair
    assign pairEnable[g] = cfgReg[PAIR_LSB + g];
    assign acCouple[g]   = cfgReg[AC_LSB + g];
  end

  assign analogPd  = cfgReg[APD_BIT];
  assign digitalPd = cfgReg[DPD_BIT];

  // R9: a write shows up on the static outputs one cycle later
  p_flags_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> (digitalPd == $past(cfgWrData[DPD_BIT]) &&
                        pairEnable == $past(cfgWrData[PAIR_LSB +: 2])));
endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NUM_CLK = 1 << SEL_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [NUM_CLK-1:0] mclkEn,
  output logic              sampleStrobe,
  output logic [CHAN_W-1:0] sampleChan
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W-1:0]  divLimit;
  logic [CNT_W:0]    divFull;
  logic [CHAN_W-1:0] scanPos;
  logic [CHAN_W-1:0] grpBase;
  logic [CHAN_W-1:0] grpLast;
  logic              grpValid;
  logic              selEn;
  logic              tick;

  // Scan-code decode: group base channel and last position index
  always_comb begin
    grpBase  = '0;
    grpLast  = '0;
    grpValid = 1'b1;
    case (ctl.mode)
      3'd1: grpLast = CHAN_W'(3);
      3'd2: grpLast = CHAN_W'(1);
      3'd3: begin grpBase = CHAN_W'(2); grpLast = CHAN_W'(1); end
      3'd4, 3'd5, 3'd6, 3'd7: grpBase = ctl.mode[CHAN_W-1:0];
      default: grpValid = 1'b0;
    endcase
  end

  always_comb begin
    divFull  = (CNT_W+1)'(1) << ctl.divShift;
    divLimit = CNT_W'(divFull - (CNT_W+1)'(1));
  end

  assign selEn = mclkEn[ctl.clkSel];
  assign tick  = !ctl.restart && !ctl.hold && selEn && (divCnt == divLimit);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.restart || ctl.hold) begin
      divCnt  <= '0;
      scanPos <= '0;
    end else if (selEn) begin
      if (divCnt == divLimit) begin
        divCnt <= '0;
        if (grpValid) scanPos <= (scanPos == grpLast) ? '0 : scanPos + CHAN_W'(1);
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleStrobe <= 1'b0;
      sampleChan   <= '0;
    end else begin
      sampleStrobe <= tick && grpValid;
      if (ctl.hold) sampleChan <= '0;
      else if (tick && grpValid) sampleChan <= grpBase + scanPos;
    end
  end

  // R5: a strobe only follows a cycle with a non-idle scan code
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(ctl.mode) != 3'd0);

  // R10: digital power-down blanks strobes and zeroes the channel
  p_pd_blank_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.hold) |-> (!sampleStrobe && sampleChan == '0));

  // R4: single-channel codes pin the channel
  p_single_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && $past(ctl.mode[2])) |-> sampleChan == $past(ctl.mode[1:0]));

  // R3: the upper pair never emits channels 0 or 1
  p_pair_upper_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && $past(ctl.mode) == 3'd3) |-> sampleChan[1]);

  // R8: a restart clears the count and suppresses the strobe
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.restart) |-> (divCnt == '0 && !sampleStrobe));
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [15:0] cfgWrData,
  input  logic [3:0]  mclkEn,
  output logic        sampleStrobe,
  output logic [1:0]  sampleChan,
  output logic [1:0]  pairEnable,
  output logic [1:0]  acCouple,
  output logic        analogPd,
  output logic        digitalPd
);
  seqCtl_t ctl;

  scan_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ctl(ctl), .pairEnable(pairEnable), .acCouple(acCouple),
    .analogPd(analogPd), .digitalPd(digitalPd)
  );

  scan_seq_dp #(.NUM_CLK(4)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mclkEn(mclkEn),
    .sampleStrobe(sampleStrobe), .sampleChan(sampleChan)
  );
endmodule

// File: tb/scan_seq_top_test.sv
module scan_seq_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [3:0]  mclkEn = '0;
  logic        sampleStrobe;
  logic [1:0]  sampleChan;
  logic [1:0]  pairEnable;
  logic [1:0]  acCouple;
  logic        analogPd;
  logic        digitalPd;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phaseTag = "";

  // bench model state
  logic [15:0] mCfg = '0;
  int mCnt = 0;
  int mPos = 0;
  logic mStrobe = 0;
  int mChan = 0;

  scan_seq_top uut (.*);

  always #4 clk = ~clk;

  function automatic int grpBase(input logic [2:0] m);
    if (m == 3) return 2;
    if (m >= 4) return m - 4;
    return 0;
  endfunction

  function automatic int grpLen(input logic [2:0] m);
    if (m == 1) return 4;
    if (m == 2 || m == 3) return 2;
    return 1;
  endfunction

  function automatic string modeTag(input logic [15:0] c);
    if (c[12]) return "R10";
    if (c[2:0] == 0) return "R5";
    if (c[2:0] == 1) return "R2";
    if (c[2:0] <= 3) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] data, input logic [3:0] mc);
    logic restart;
    logic hold;
    int limit;
    string tag;
    @(negedge clk);
    cfgWrEn = wr; cfgWrData = data; mclkEn = mc;
    @(posedge clk);
    restart = wr && (data[6:0] != mCfg[6:0]);
    hold = mCfg[12];
    limit = (1 << mCfg[6:5]) - 1;
    tag = (phaseTag != "") ? phaseTag : modeTag(mCfg);
    mStrobe = 0;
    if (restart || hold) begin
      mCnt = 0; mPos = 0;
      if (hold) mChan = 0;
    end else if (mc[mCfg[4:3]]) begin
      if (mCnt == limit) begin
        mCnt = 0;
        if (mCfg[2:0] != 0) begin
          mStrobe = 1;
          mChan = grpBase(mCfg[2:0]) + mPos;
          mPos = (mPos + 1) % grpLen(mCfg[2:0]);
        end
      end else mCnt++;
    end
    if (wr) mCfg = data;
    #1;
    check(tag, int'(sampleStrobe), int'(mStrobe));
    if (mStrobe || hold) check(tag, int'(sampleChan), mChan);
    if (wr) begin
      check("R9", int'({digitalPd, analogPd, acCouple, pairEnable}), int'(data[12:7]));
    end
  endtask

  task automatic run(input int n, input logic [3:0] mc);
    for (int i = 0; i < n; i++) step(1'b0, '0, mc);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int dummy;
    dummy = $urandom(32'h5EED1234);
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'({sampleStrobe, sampleChan, pairEnable, acCouple, analogPd, digitalPd}), 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1", int'({sampleStrobe, sampleChan, pairEnable, acCouple, analogPd, digitalPd}), 0);

    // R5: idle code with busy clock
    phaseTag = "R5";
    run(20, 4'hF);
    // R2: full scan, clock 0, no divide
    phaseTag = "R2";
    step(1'b1, 16'h0181, 4'h0);
    run(16, 4'h1);
    // R3: both pairs
    phaseTag = "R3";
    step(1'b1, 16'h0002, 4'h0); run(10, 4'h1);
    step(1'b1, 16'h0003, 4'h0); run(10, 4'h1);
    // R4: every single channel
    phaseTag = "R4";
    for (int k = 4; k < 8; k++) begin
      step(1'b1, 16'(k), 4'h0); run(6, 4'h1);
    end
    // R6: select clock 2, pulse the others only, then the selected one
    phaseTag = "R6";
    step(1'b1, 16'h0011, 4'h0); run(20, 4'hB); run(8, 4'h4);
    // R7: divide by 8 on an every-cycle enable
    phaseTag = "R7";
    step(1'b1, 16'h0061, 4'h0); run(40, 4'h1);
    step(1'b1, 16'h0021, 4'h0); run(12, 4'h1);
    // R8: identical rewrite vs changed write
    phaseTag = "R8";
    step(1'b1, 16'h0041, 4'h0); run(5, 4'h1);
    step(1'b1, 16'h0241, 4'h1); run(6, 4'h1);
    step(1'b1, 16'h0021, 4'h1); run(10, 4'h1);
    // R10: power-down window and reset/resync sequence
    phaseTag = "R10";
    step(1'b1, 16'h1821, 4'h1); run(6, 4'h1);
    step(1'b1, 16'h1021, 4'h1); run(6, 4'h1);
    step(1'b1, 16'h0021, 4'h1); run(10, 4'h1);
    // R9: flag patterns
    phaseTag = "R9";
    step(1'b1, 16'h0A81, 4'h0);
    step(1'b1, 16'h1501, 4'h0);
    step(1'b1, 16'h0001, 4'h0);

    // random phase, tags from current scan code
    phaseTag = "";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        w = 16'($urandom());
        if ($urandom_range(0, 3) != 0) w[12] = 1'b0;
        step(1'b1, w, 4'($urandom()));
      end else begin
        step(1'b0, '0, 4'($urandom()));
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule